// File: doc/BRIEF.md
# Audio Control Register Slave on a Two-Wire Serial Bus

This block is a write-only two-wire (I2C) serial slave that holds the control settings of a stereo tone and volume processor. It oversamples the bus clock and data lines with a fast system clock, recognises start and stop conditions, and checks the first byte of a transfer against a fixed 7-bit device address with a write direction bit. The second byte selects a register. Every byte after that is written to the selected register, and the selection then steps to the next register, so a host can load the whole control set in a single transfer.

There are five registers: left volume, right volume, bass, treble, and a switch word that carries the mute flag, the stereo/spatial/mono processing mode and the input source. Each value is brought into its legal range as it is written. The outputs are the resulting control codes, ready for the analog stages. The slave acknowledges by pulling the data line low. It never returns data and never holds the clock low.

Top module: `audio_ctl_i2c_slave`

## Requirements
- R1: A falling edge of SDA while SCL is high is a start and sets `bus_busy` to 1. A rising edge of SDA while SCL is high is a stop and clears `bus_busy` to 0.
- R2: A start resets the receiver at any point, including in the middle of a transfer. The next byte is then taken as an address byte, never as data.
- R3: An address byte equal to {DEV_ADDR, 0} is acknowledged. Any other address byte, including {DEV_ADDR, 1}, gets no acknowledge, and every byte up to the next start is ignored and not acknowledged.
- R4: The byte after a matching address is the register index: 0 left volume, 1 right volume, 2 bass, 3 treble, 4 switch. Each following data byte is acknowledged and written to the current index, and the index then increments by one.
- R5: A volume byte of 0 to 35 is stored unchanged (code n means 6 − 2n dB). A byte of 36 or more is stored as 36, the deep-attenuation step.
- R6: A bass byte above 9 is stored as 9 (code n means 3n − 12 dB). A treble byte above 8 is stored as 8 (code n means 3n − 12 dB). Smaller values are stored unchanged.
- R7: In the switch byte, bit 0 is mute (1 means muted). Bits 2:1 are the mode (0 stereo, 1 spatial, 2 mono), and 3 is stored as 2. Bits 4:3 are the source (0 stereo, 1 sound A, 2 sound B), and 3 is stored as 2.
- R8: Reset sets mute to 1, both volumes to 36, bass and treble to 4 (0 dB), mode and source to 0, `sda_oe` to 0 and `bus_busy` to 0.
- R9: A data byte written at an index above 4 is acknowledged but changes no register. The index does not wrap back to 0.
- R10: `sda_oe` changes only while SCL is low, and it is high only for the acknowledge bit that follows a byte the slave accepts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| bus_busy | output | 1 | 1 between a start and a stop |
| vol_l | output | 6 | Left volume code, 0..36 |
| vol_r | output | 6 | Right volume code, 0..36 |
| bass | output | 4 | Bass code, 0..9 |
| treble | output | 4 | Treble code, 0..8 |
| mute | output | 1 | Mute, 1 means muted |
| mode | output | 2 | Processing mode: 0 stereo, 1 spatial, 2 mono |
| source | output | 2 | Input source: 0 stereo, 1 sound A, 2 sound B |

## Verification
The bench repeats a start right after the index byte. A receiver that ignores the start would write the new address byte into right volume as data. It sends a foreign address and an address with the read bit set. A slave that matched loosely would acknowledge and overwrite left volume. It writes out-of-range bytes into every field, so missing clamps would leave codes such as 50, 15 or 3 on the outputs. It also runs the index past the switch register. An index that wrapped would overwrite left volume, and an index that was not range-checked would corrupt the switch word.

// File: rtl/audio_ctl_i2c_slave.sv
module audio_ctl_i2c_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h41
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       bus_busy,
  output logic [5:0] vol_l,
  output logic [5:0] vol_r,
  output logic [3:0] bass,
  output logic [3:0] treble,
  output logic       mute,
  output logic [1:0] mode,
  output logic [1:0] source
);
  localparam logic [7:0] VOL_FLOOR = 8'd36;
  localparam logic [7:0] BASS_TOP  = 8'd9;
  localparam logic [7:0] TREB_TOP  = 8'd8;
  localparam logic [7:0] TONE_MID  = 8'd4;
  localparam logic [7:0] SUB_LAST  = 8'd4;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_SUB, PH_DATA} phase_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  phase_t     phase;
  logic [3:0] bitn;
  logic [7:0] shreg, sub;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end
  end

  wire scl      = scl_sy[1];
  wire sda      = sda_sy[1];
  wire scl_rise = scl & ~scl_q;
  wire scl_fall = ~scl & scl_q;
  wire start_c  = scl & scl_q & sda_q & ~sda;
  wire stop_c   = scl & scl_q & ~sda_q & sda;
  wire byte_end = scl_fall && (bitn == 4'd8);
  wire wr_en    = byte_end && (phase == PH_DATA) && !start_c && !stop_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      bitn     <= 4'd0;
      shreg    <= 8'd0;
      sub      <= 8'd0;
      sda_oe   <= 1'b0;
      bus_busy <= 1'b0;
    end else if (start_c) begin
      phase    <= PH_ADDR;
      bitn     <= 4'd0;
      sda_oe   <= 1'b0;
      bus_busy <= 1'b1;
    end else if (stop_c) begin
      phase    <= PH_IDLE;
      bitn     <= 4'd0;
      sda_oe   <= 1'b0;
      bus_busy <= 1'b0;
    end else if (phase != PH_IDLE) begin
      if (scl_rise) begin
        if (bitn < 4'd8) begin
          shreg <= {shreg[6:0], sda};
          bitn  <= bitn + 4'd1;
        end else begin
          bitn <= 4'd9;
        end
      end else if (byte_end) begin
        sda_oe <= 1'b1;
        case (phase)
          PH_ADDR:
            if (shreg == {DEV_ADDR, 1'b0}) phase <= PH_SUB;
            else begin
              phase  <= PH_IDLE;
              sda_oe <= 1'b0;
            end
          PH_SUB: begin
            sub   <= shreg;
            phase <= PH_DATA;
          end
          default:
            if (sub != 8'hFF) sub <= sub + 8'd1;
        endcase
      end else if (scl_fall && bitn == 4'd9) begin
        sda_oe <= 1'b0;
        bitn   <= 4'd0;
      end
    end
  end

  wire [5:0] vol_n  = (shreg >= VOL_FLOOR) ? VOL_FLOOR[5:0] : shreg[5:0];
  wire [3:0] bass_n = (shreg > BASS_TOP) ? BASS_TOP[3:0] : shreg[3:0];
  wire [3:0] treb_n = (shreg > TREB_TOP) ? TREB_TOP[3:0] : shreg[3:0];
  wire [1:0] mode_n = (shreg[2:1] == 2'd3) ? 2'd2 : shreg[2:1];
  wire [1:0] src_n  = (shreg[4:3] == 2'd3) ? 2'd2 : shreg[4:3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vol_l  <= VOL_FLOOR[5:0];
      vol_r  <= VOL_FLOOR[5:0];
      bass   <= TONE_MID[3:0];
      treble <= TONE_MID[3:0];
      mute   <= 1'b1;
      mode   <= 2'd0;
      source <= 2'd0;
    end else if (wr_en && sub <= SUB_LAST) begin
      case (sub[2:0])
        3'd0: vol_l  <= vol_n;
        3'd1: vol_r  <= vol_n;
        3'd2: bass   <= bass_n;
        3'd3: treble <= treb_n;
        default: begin
          mute   <= shreg[0];
          mode   <= mode_n;
          source <= src_n;
        end
      endcase
    end
  end
endmodule

// File: rtl/audio_ctl_i2c_chk.sv
module audio_ctl_i2c_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       bus_busy,
  input logic [5:0] vol_l,
  input logic [5:0] vol_r,
  input logic [3:0] bass,
  input logic [3:0] treble,
  input logic       mute,
  input logic [1:0] mode,
  input logic [1:0] source
);
  a_r8_reset_state: assert property (@(posedge clk)
    !rst_n |=> (mute && vol_l == 6'd36 && vol_r == 6'd36 && !sda_oe && !bus_busy));

  a_r5_vol_range: assert property (@(posedge clk) disable iff (!rst_n)
    vol_l <= 6'd36 && vol_r <= 6'd36);

  a_r6_tone_range: assert property (@(posedge clk) disable iff (!rst_n)
    bass <= 4'd9 && treble <= 4'd8);

  a_r7_switch_codes: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3 && source != 2'd3);

  a_r10_ack_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  a_r10_ack_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_i);

  a_r1_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_busy |-> !sda_oe);
endmodule

bind audio_ctl_i2c_slave audio_ctl_i2c_chk u_chk (.*);

// File: tb/sim_audio_ctl_i2c_slave.sv
module sim_audio_ctl_i2c_slave;
  localparam logic [6:0] ADDR = 7'h41;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe, bus_busy, mute;
  logic [5:0] vol_l, vol_r;
  logic [3:0] bass, treble;
  logic [1:0] mode, source;
  wire sda_line = m_sda & ~sda_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit oe_in_data = 1'b0;

  always #2 clk = ~clk;

  audio_ctl_i2c_slave #(.DEV_ADDR(ADDR)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .bus_busy(bus_busy), .vol_l(vol_l), .vol_r(vol_r),
    .bass(bass), .treble(treble), .mute(mute), .mode(mode), .source(source));

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wt(Q);
    m_scl = 1'b1; wt(Q);
    m_sda = 1'b0; wt(Q);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wt(Q);
    m_scl = 1'b1; wt(Q);
    m_sda = 1'b1; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wt(Q);
      m_scl = 1'b1; wt(Q);
      if (sda_oe) oe_in_data = 1'b1;
      wt(Q);
      m_scl = 1'b0; wt(Q);
    end
    m_sda = 1'b1; wt(Q);
    m_scl = 1'b1; wt(Q);
    ack = ~sda_line;
    wt(Q);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic t_reset();
    chk("R8 mute", mute, 1);
    chk("R8 vol_l", vol_l, 36);
    chk("R8 vol_r", vol_r, 36);
    chk("R8 bass", bass, 4);
    chk("R8 treble", treble, 4);
    chk("R8 mode", mode, 0);
    chk("R8 source", source, 0);
    chk("R8 sda_oe", sda_oe, 0);
    chk("R1 idle busy", bus_busy, 0);
  endtask

  task automatic t_burst();
    bit a;
    logic [7:0] d [5] = '{8'd0, 8'd10, 8'd9, 8'd0, 8'h12};
    i2c_start();
    chk("R1 busy after start", bus_busy, 1);
    send_byte({ADDR, 1'b0}, a); chk("R3 address ack", a, 1);
    send_byte(8'd0, a);         chk("R4 index ack", a, 1);
    foreach (d[k]) begin
      send_byte(d[k], a);
      chk("R4 data ack", a, 1);
    end
    i2c_stop();
    chk("R1 free after stop", bus_busy, 0);
    chk("R4 vol_l", vol_l, 0);
    chk("R4 vol_r", vol_r, 10);
    chk("R4 bass", bass, 9);
    chk("R4 treble", treble, 0);
    chk("R7 mute cleared", mute, 0);
    chk("R7 mode spatial", mode, 1);
    chk("R7 source B", source, 2);
    chk("R10 no drive during data bits", oe_in_data, 0);
    chk("R10 released after transfer", sda_oe, 0);
  endtask

  task automatic t_clamp();
    bit a;
    logic [7:0] d [5] = '{8'd50, 8'd35, 8'd15, 8'd12, 8'h1F};
    i2c_start();
    send_byte({ADDR, 1'b0}, a);
    send_byte(8'd0, a);
    foreach (d[k]) send_byte(d[k], a);
    i2c_stop();
    chk("R5 vol_l clamp", vol_l, 36);
    chk("R5 vol_r in range", vol_r, 35);
    chk("R6 bass clamp", bass, 9);
    chk("R6 treble clamp", treble, 8);
    chk("R7 mute set", mute, 1);
    chk("R7 mode 3 to mono", mode, 2);
    chk("R7 source 3 to B", source, 2);
  endtask

  task automatic t_wrong_addr();
    bit a;
    i2c_start();
    send_byte({ADDR ^ 7'h01, 1'b0}, a); chk("R3 foreign address nack", a, 0);
    send_byte(8'd0, a);                chk("R3 ignored byte nack", a, 0);
    send_byte(8'd5, a);                chk("R3 ignored data nack", a, 0);
    i2c_stop();
    chk("R3 vol_l untouched", vol_l, 36);
    i2c_start();
    send_byte({ADDR, 1'b1}, a); chk("R3 read bit nack", a, 0);
    send_byte(8'd0, a);
    send_byte(8'd7, a);
    i2c_stop();
    chk("R3 vol_l untouched after read", vol_l, 36);
  endtask

  task automatic t_restart();
    bit a;
    i2c_start();
    send_byte({ADDR, 1'b0}, a);
    send_byte(8'd1, a);
    i2c_start();
    chk("R2 busy across restart", bus_busy, 1);
    send_byte({ADDR, 1'b0}, a); chk("R2 address after restart", a, 1);
    send_byte(8'd0, a);
    send_byte(8'd3, a);
    i2c_stop();
    chk("R2 vol_r not written", vol_r, 35);
    chk("R2 vol_l written", vol_l, 3);
  endtask

  task automatic t_beyond();
    bit a;
    i2c_start();
    send_byte({ADDR, 1'b0}, a);
    send_byte(8'd4, a);
    send_byte(8'h00, a); chk("R4 switch ack", a, 1);
    send_byte(8'h1F, a); chk("R9 index 5 ack", a, 1);
    send_byte(8'd7, a);  chk("R9 index 6 ack", a, 1);
    i2c_stop();
    chk("R9 mute kept", mute, 0);
    chk("R9 mode kept", mode, 0);
    chk("R9 source kept", source, 0);
    chk("R9 no wrap vol_l", vol_l, 3);
    chk("R9 no wrap vol_r", vol_r, 35);
  endtask

  initial begin
    wt(5);
    rst_n = 1'b1;
    wt(5);
    t_reset();
    t_burst();
    t_clamp();
    t_wrong_addr();
    t_restart();
    t_beyond();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule